// File: doc/BRIEF.md
# Multicart Outer Bank OR-Mask Mapper

This block selects which game of a multicart is visible to the CPU. It sits next to an ordinary inner bank controller. The inner controller still produces the switchable ROM bank number. This block ORs an outer mask into that number before the number drives ROM address lines A21-A14. With a mask of zero, the menu image at bank 0 shows. With a mask equal to a game's start bank, that game shows and keeps its own bank switching inside its window.

Software loads the mask in three steps. First it opens configuration mode by writing a key byte to a control address. Next it writes the start bank to the inner bank register address, where a side latch copies the byte. Then it writes any value to a commit address, which copies the latch into the mask. A second key byte closes configuration mode, so later bank writes from the game cannot change the mask. The RAM bank from the inner controller passes through unchanged.

Top module: `multicart_or_mapper`

## Requirements
- R1: After reset the mask is 00h and configuration mode is closed. A read at 4000h-7FFFh then yields the inner bank unchanged, and a read at 0000h-3FFFh yields bank 00h.
- R2: Every write to 2000h stores its data byte in the side latch. The latch is observed through a later commit.
- R3: Writing A5h to 1000h opens configuration mode. Writing 98h to 1000h closes it.
- R4: Writing any other byte to 1000h leaves configuration mode as it was.
- R5: While configuration mode is open, a write of any value to 7000h copies the latch into the mask. The new mask is visible from the clock edge that takes the write.
- R6: While configuration mode is closed, a write to 7000h leaves the mask unchanged.
- R7: For a read at 4000h-7FFFh, `rom_bank_o` equals `inner_bank_i` bitwise ORed with the mask.
- R8: For a read at 0000h-3FFFh (address bits 15:14 = 00), `rom_bank_o` equals the mask.
- R9: `ram_bank_o` always equals `ram_bank_i`, whatever the mask.
- R10: The control, latch and commit addresses are decoded on all 16 address bits. Writes to 1001h, 2001h and 7001h have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_i | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr_i | input | 16 | CPU address for reads and writes |
| cpu_data_i | input | 8 | CPU write data |
| inner_bank_i | input | 8 | Switchable ROM bank from the inner controller |
| ram_bank_i | input | 4 | RAM bank from the inner controller |
| rom_bank_o | output | 8 | Bank number for ROM lines A21-A14 |
| ram_bank_o | output | 4 | RAM bank forwarded unchanged |

## Verification
Every write takes effect at the rising edge where `cpu_wr_i` is high. The bank output is combinational from the address, the inner bank and the mask, so a committed mask shows on `rom_bank_o` straight after that edge. The bench therefore sets inputs on the falling edge and holds each write for exactly one cycle. On the next falling edge it sets the read address and inner bank, then samples the outputs 1 ns later, before any further edge. The latch and configuration mode are internal, so their effect is checked through a later commit and the resulting bank number.

// File: rtl/mcor_pkg.sv
package mcor_pkg;
   typedef enum logic {
      CFG_LOCKED = 1'b0,
      CFG_OPEN   = 1'b1
   } cfg_state_t;

   function automatic logic addr_hit(input logic [15:0] a, input logic [15:0] target);
      return a == target;
   endfunction
endpackage

// File: rtl/mcor_cfg_gate.sv
module mcor_cfg_gate
   import mcor_pkg::*;
#(
   parameter int              DATA_W     = 8,
   parameter logic [15:0]     CTRL_ADDR  = 16'h1000,
   parameter logic [DATA_W-1:0] UNLOCK_KEY = 8'hA5,
   parameter logic [DATA_W-1:0] LOCK_KEY   = 8'h98
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [15:0]       addr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              open_o
);
   generate
      if (UNLOCK_KEY == LOCK_KEY) begin : g_bad_keys
         $error("mcor_cfg_gate: unlock and lock keys must differ");
      end
   endgenerate

   cfg_state_t state_q;
   logic       ctrl_wr;

   assign ctrl_wr = wr_i && addr_hit(addr_i, CTRL_ADDR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= CFG_LOCKED;
      end else if (ctrl_wr && data_i == UNLOCK_KEY) begin
         state_q <= CFG_OPEN;
      end else if (ctrl_wr && data_i == LOCK_KEY) begin
         state_q <= CFG_LOCKED;
      end
   end

   assign open_o = (state_q == CFG_OPEN);

   AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && data_i == UNLOCK_KEY) |=> open_o); // R3
   AST_KEY_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && data_i == LOCK_KEY) |=> !open_o); // R3
   AST_OTHER_BYTE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && addr_i == CTRL_ADDR && data_i != UNLOCK_KEY && data_i != LOCK_KEY)
      |=> $stable(open_o)); // R4
endmodule

// File: rtl/mcor_outer_mask.sv
module mcor_outer_mask
   import mcor_pkg::*;
#(
   parameter int          DATA_W      = 8,
   parameter int          BANK_W      = 8,
   parameter logic [15:0] LATCH_ADDR  = 16'h2000,
   parameter logic [15:0] COMMIT_ADDR = 16'h7000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [15:0]       addr_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              open_i,
   output logic [BANK_W-1:0] mask_o
);
   generate
      if (BANK_W > DATA_W) begin : g_bad_width
         $error("mcor_outer_mask: bank wider than data bus");
      end
   endgenerate

   logic [DATA_W-1:0] side_q;
   logic [BANK_W-1:0] mask_q;
   logic              latch_wr;
   logic              commit_wr;

   assign latch_wr  = wr_i && addr_hit(addr_i, LATCH_ADDR);
   assign commit_wr = wr_i && addr_hit(addr_i, COMMIT_ADDR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         side_q <= '0;
      end else if (latch_wr) begin
         side_q <= data_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else if (commit_wr && open_i) begin
         mask_q <= side_q[BANK_W-1:0];
      end
   end

   assign mask_o = mask_q;

   AST_LATCH_TAKES_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      latch_wr |=> side_q == $past(data_i)); // R2
   AST_COMMIT_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_wr && open_i) |=> mask_o == $past(side_q[BANK_W-1:0])); // R5
   AST_COMMIT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_wr && !open_i) |=> $stable(mask_o)); // R6
   AST_NO_STRAY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_wr |=> $stable(mask_o)); // R10
endmodule

// File: rtl/mcor_bank_merge.sv
module mcor_bank_merge #(
   parameter int BANK_W   = 8,
   parameter bit OR_FIXED = 1'b1
) (
   input  logic              fixed_sel_i,
   input  logic [BANK_W-1:0] inner_i,
   input  logic [BANK_W-1:0] mask_i,
   output logic [BANK_W-1:0] bank_o
);
   logic [BANK_W-1:0] base;

   assign base = fixed_sel_i ? '0 : inner_i;

   generate
      if (OR_FIXED) begin : g_or_all
         assign bank_o = base | mask_i;
      end else begin : g_or_switch
         assign bank_o = fixed_sel_i ? '0 : (base | mask_i);
      end
   endgenerate
endmodule

// File: rtl/multicart_or_mapper.sv
module multicart_or_mapper #(
   parameter int          DATA_W      = 8,
   parameter int          BANK_W      = 8,
   parameter int          RAM_W       = 4,
   parameter bit          OR_FIXED    = 1'b1,
   parameter logic [15:0] CTRL_ADDR   = 16'h1000,
   parameter logic [15:0] LATCH_ADDR  = 16'h2000,
   parameter logic [15:0] COMMIT_ADDR = 16'h7000,
   parameter logic [7:0]  UNLOCK_KEY  = 8'hA5,
   parameter logic [7:0]  LOCK_KEY    = 8'h98
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr_i,
   input  logic [15:0]       cpu_addr_i,
   input  logic [DATA_W-1:0] cpu_data_i,
   input  logic [BANK_W-1:0] inner_bank_i,
   input  logic [RAM_W-1:0]  ram_bank_i,
   output logic [BANK_W-1:0] rom_bank_o,
   output logic [RAM_W-1:0]  ram_bank_o
);
   localparam int KEY_W = (DATA_W < 8) ? DATA_W : 8;

   generate
      if (DATA_W < 8) begin : g_bad_data
         $error("multicart_or_mapper: key bytes need an 8-bit data bus");
      end
      if (CTRL_ADDR == LATCH_ADDR || CTRL_ADDR == COMMIT_ADDR || LATCH_ADDR == COMMIT_ADDR) begin : g_bad_map
         $error("multicart_or_mapper: control addresses must be distinct");
      end
   endgenerate

   logic              cfg_open;
   logic [BANK_W-1:0] mask;
   logic              fixed_sel;

   mcor_cfg_gate #(
      .DATA_W    (DATA_W),
      .CTRL_ADDR (CTRL_ADDR),
      .UNLOCK_KEY(DATA_W'(UNLOCK_KEY[KEY_W-1:0])),
      .LOCK_KEY  (DATA_W'(LOCK_KEY[KEY_W-1:0]))
   ) u_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_i  (cpu_wr_i),
      .addr_i(cpu_addr_i),
      .data_i(cpu_data_i),
      .open_o(cfg_open)
   );

   mcor_outer_mask #(
      .DATA_W     (DATA_W),
      .BANK_W     (BANK_W),
      .LATCH_ADDR (LATCH_ADDR),
      .COMMIT_ADDR(COMMIT_ADDR)
   ) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_i  (cpu_wr_i),
      .addr_i(cpu_addr_i),
      .data_i(cpu_data_i),
      .open_i(cfg_open),
      .mask_o(mask)
   );

   assign fixed_sel = (cpu_addr_i[15:14] == 2'b00);

   mcor_bank_merge #(
      .BANK_W  (BANK_W),
      .OR_FIXED(OR_FIXED)
   ) u_merge (
      .fixed_sel_i(fixed_sel),
      .inner_i    (inner_bank_i),
      .mask_i     (mask),
      .bank_o     (rom_bank_o)
   );

   assign ram_bank_o = ram_bank_i;

   AST_MASK_BITS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_bank_o & mask) == mask); // R7
   AST_INNER_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      !fixed_sel |-> (rom_bank_o & inner_bank_i) == inner_bank_i); // R7
   AST_RESET_MASK_CLEAR: assert property (@(posedge clk)
      !rst_n |=> mask == '0); // R1
endmodule

// File: tb/sim_multicart_or_mapper.sv
module sim_multicart_or_mapper;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_wr_i = 1'b0;
   logic [15:0] cpu_addr_i = 16'h4000;
   logic [7:0]  cpu_data_i = 8'h00;
   logic [7:0]  inner_bank_i = 8'h00;
   logic [3:0]  ram_bank_i = 4'h0;
   logic [7:0]  rom_bank_o;
   logic [3:0]  ram_bank_o;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   multicart_or_mapper u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .cpu_wr_i    (cpu_wr_i),
      .cpu_addr_i  (cpu_addr_i),
      .cpu_data_i  (cpu_data_i),
      .inner_bank_i(inner_bank_i),
      .ram_bank_i  (ram_bank_i),
      .rom_bank_o  (rom_bank_o),
      .ram_bank_o  (ram_bank_o)
   );

   // {req[3:0], write addr[15:0], write data[7:0], inner bank[7:0], expected bank at 4000h[7:0]}
   localparam int NV = 16;
   localparam logic [43:0] VEC [NV] = '{
      {4'd3,  16'h1000, 8'hA5, 8'h03, 8'h03},
      {4'd2,  16'h2000, 8'h20, 8'h03, 8'h03},
      {4'd5,  16'h7000, 8'h55, 8'h03, 8'h23},
      {4'd3,  16'h1000, 8'h98, 8'h05, 8'h25},
      {4'd2,  16'h2000, 8'h40, 8'h01, 8'h21},
      {4'd6,  16'h7000, 8'h00, 8'h01, 8'h21},
      {4'd3,  16'h1000, 8'hA5, 8'h10, 8'h30},
      {4'd4,  16'h1000, 8'h00, 8'h00, 8'h20},
      {4'd4,  16'h7000, 8'hFF, 8'h00, 8'h40},
      {4'd10, 16'h2001, 8'h80, 8'h01, 8'h41},
      {4'd10, 16'h7000, 8'h00, 8'h01, 8'h41},
      {4'd10, 16'h1001, 8'h98, 8'h02, 8'h42},
      {4'd2,  16'h2000, 8'h0F, 8'h02, 8'h42},
      {4'd10, 16'h7001, 8'h00, 8'h02, 8'h42},
      {4'd5,  16'h7000, 8'h00, 8'h02, 8'h0F},
      {4'd7,  16'h1000, 8'h98, 8'hF0, 8'hFF}
   };

   task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_addr_i = a;
      cpu_data_i = d;
      cpu_wr_i   = 1'b1;
      @(negedge clk);
      cpu_wr_i   = 1'b0;
   endtask

   task automatic read_at(input logic [15:0] a, input logic [7:0] inner);
      cpu_addr_i   = a;
      inner_bank_i = inner;
      #1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      read_at(16'h4000, 8'h07);
      check8("R1 switch region after reset", rom_bank_o, 8'h07);
      read_at(16'h0123, 8'h07);
      check8("R1 fixed region after reset", rom_bank_o, 8'h00);

      for (int i = 0; i < NV; i++) begin
         cpu_write(VEC[i][39:24], VEC[i][23:16]);
         read_at(16'h4000, VEC[i][15:8]);
         check8($sformatf("R%0d vector %0d", VEC[i][43:40], i), rom_bank_o, VEC[i][7:0]);
      end

      // R8: fixed region shows the mask (0Fh)
      read_at(16'h3FFF, 8'hF0);
      check8("R8 fixed region", rom_bank_o, 8'h0F);
      read_at(16'h7FFF, 8'h30);
      check8("R7 top of switch region", rom_bank_o, 8'h3F);

      // R9: RAM bank forwarded unchanged while mask is nonzero
      ram_bank_i = 4'hA;
      read_at(16'hA000, 8'h00);
      checks++;
      if (ram_bank_o !== 4'hA) begin
         fails++;
         $display("FAIL R9: actual %0h expected a", ram_bank_o);
      end

      // R10: strobe low means no write
      @(negedge clk);
      cpu_addr_i = 16'h1000; cpu_data_i = 8'hA5; cpu_wr_i = 1'b0;
      @(negedge clk);
      cpu_write(16'h2000, 8'h80);
      cpu_write(16'h7000, 8'h00);
      read_at(16'h4000, 8'h00);
      check8("R10 write without strobe", rom_bank_o, 8'h0F);

      // R1: reset clears a nonzero mask
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      read_at(16'h4000, 8'h11);
      check8("R1 mask cleared by reset", rom_bank_o, 8'h11);
      cpu_write(16'h2000, 8'h80);
      cpu_write(16'h7000, 8'h00);
      read_at(16'h4000, 8'h11);
      check8("R1 mode closed after reset", rom_bank_o, 8'h11);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule